// File: doc/BRIEF.md
# Fault-Injecting Word Memory

This block is a single-port 16-bit word memory that behaves like an unreliable part: now and then one bit of a word is inverted on the way in or on the way out. It sits in an address space at an aligned base and answers to a power-of-two number of words above that base. A free-running 32-bit linear feedback shift register supplies the randomness. One slice of its state decides whether an access is corrupted, and a separate 4-bit field picks which bit flips. Writes are corrupted about half as often as reads.

After reset the block fills the whole array before it serves the bus. The fill source is chosen by an input sampled while reset is held. In pattern mode an eight-word sequence repeats across the array. In random mode each word takes the low half of the generator state. While the fill runs, `busy` is high and bus requests are dropped.

Top module: `fault_mem`

## Requirements
- R1: While `rst` is high and for exactly DEPTH rising edges after it falls, `busy` is 1. While `rst` is high, `rvalid` and `rdata` are 0. The first access is accepted on edge DEPTH after release, counting from edge 0.
- R2: With `fill_rnd` = 0 during reset, word i is filled with entry (i mod 8) of this sequence, entry 0 first: 0x0204, 0x0255, 0x4104, 0x0020, 0xF460, 0x0080, 0x0120, 0x0404.
- R3: With `fill_rnd` = 1 during reset, word i is filled on fill edge i with bits [15:0] of the generator state present at that edge.
- R4: The generator is a 32-bit register that loads SEED on every reset edge. On every other edge it shifts right by one, and when the bit shifted out is 1 it is XORed with 0x80200003.
- R5: An address hits when its bits above SIZE_LOG2 equal those of BASE. The low SIZE_LOG2 bits select the word. Misses neither write nor read.
- R6: An accepted write (`req`=1, `we`=1, hit, not busy) stores `wdata` at the selected word on that edge, possibly corrupted as set out in R9.
- R7: An accepted read (`req`=1, `we`=0, hit, not busy) raises `rvalid` for one cycle after the edge, with `rdata` holding the word. A missed read leaves `rvalid` at 0.
- R8: When generator bits [15:0] equal 3 at the edge of an accepted read, `rdata` is the stored word XOR (1 << generator bits [23:20]). The stored word is not changed.
- R9: When generator bits [16:0] equal 3 at the edge of an accepted write, the stored word is `wdata` XOR (1 << generator bits [23:20]).
- R10: Requests presented while `busy` is 1 change no word and raise no `rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fill_rnd | input | 1 | Fill source sampled in reset: 0 pattern, 1 generator |
| req | input | 1 | Access request |
| we | input | 1 | 1 write, 0 read |
| addr | input | ADDR_W | Word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid with rvalid |
| rvalid | output | 1 | Read result valid |
| busy | output | 1 | Fill in progress; requests ignored |

## Verification
Embedded properties check the per-cycle rules on every cycle. Busy is raised when reset is released and stays up for the full fill length. No read result appears during the fill or for an address outside the window. The generator never reaches the all-zero state. A read or a write never differs from its source word in more than one bit. Which bit flips, and on which cycle, is shown only by the bench scenarios: the bench predicts the generator from the seed and places accesses on the cycles where the trigger field matches. The bench also shows the fill contents of both modes, the rule that a read glitch leaves the stored word untouched, and the dropping of requests while busy.

// File: rtl/fim_pkg.sv
package fim_pkg;

    localparam int DATA_W       = 16;
    localparam int BITSEL_W     = $clog2(DATA_W);
    localparam int GEN_W        = 32;
    localparam int BITSEL_LSB   = 20;
    localparam int RD_TRIG_BITS = 16;
    localparam int WR_TRIG_BITS = 17;
    localparam int TRIG_VALUE   = 3;
    localparam int PAT_LEN      = 8;
    localparam logic [GEN_W-1:0] GEN_TAPS = 32'h8020_0003;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [GEN_W-1:0]  gen_t;

    typedef struct packed {
        logic  fire;
        word_t mask;
    } flip_t;

    typedef enum logic {
        FILL_ACTIVE = 1'b0,
        FILL_DONE   = 1'b1
    } fill_state_t;

    function automatic gen_t gen_next(input gen_t s);
        return (s >> 1) ^ (s[0] ? GEN_TAPS : '0);
    endfunction

    function automatic flip_t flip_of(input gen_t s, input int trig_bits);
        flip_t f;
        gen_t  m;
        m      = (gen_t'(1) << trig_bits) - gen_t'(1);
        f.fire = ((s & m) == gen_t'(TRIG_VALUE));
        f.mask = f.fire ? (word_t'(1) << s[BITSEL_LSB +: BITSEL_W]) : '0;
        return f;
    endfunction

    function automatic word_t fill_pattern(input logic [2:0] k);
        word_t w;
        case (k)
            3'd0:    w = 16'h0204;
            3'd1:    w = 16'h0255;
            3'd2:    w = 16'h4104;
            3'd3:    w = 16'h0020;
            3'd4:    w = 16'hF460;
            3'd5:    w = 16'h0080;
            3'd6:    w = 16'h0120;
            default: w = 16'h0404;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/fim_lfsr.sv
module fim_lfsr
    import fim_pkg::*;
#(
    parameter gen_t SEED = 32'hACE1_0001
) (
    input  logic clk,
    input  logic rst,
    output gen_t state
);

    always_ff @(posedge clk) begin
        if (rst) state <= SEED;
        else     state <= gen_next(state);
    end

    AST_GEN_NONZERO: assert property (@(posedge clk) disable iff (rst)
        state != '0); // R4

endmodule

// File: rtl/fim_flip.sv
module fim_flip
    import fim_pkg::*;
#(
    parameter int TRIG_BITS = RD_TRIG_BITS
) (
    input  gen_t  state,
    output flip_t flip
);

    always_comb flip = flip_of(state, TRIG_BITS);

endmodule

// File: rtl/fim_decode.sv
module fim_decode #(
    parameter int              ADDR_W    = 16,
    parameter int              SIZE_LOG2 = 6,
    parameter logic [ADDR_W-1:0] BASE    = 16'h0400
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic                 hit,
    output logic [SIZE_LOG2-1:0] idx
);

    localparam int TAG_W = ADDR_W - SIZE_LOG2;
    localparam logic [TAG_W-1:0] BASE_TAG = BASE[ADDR_W-1:SIZE_LOG2];

    always_comb begin
        hit = (addr[ADDR_W-1:SIZE_LOG2] == BASE_TAG);
        idx = addr[SIZE_LOG2-1:0];
    end

endmodule

// File: rtl/fim_fill.sv
module fim_fill
    import fim_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     fill_rnd,
    output logic                     busy,
    output logic                     fill_we,
    output logic [$clog2(DEPTH)-1:0] fill_idx,
    output logic                     rnd_mode
);

    localparam int IDX_W = $clog2(DEPTH);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    fill_state_t st;
    logic [IDX_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= FILL_ACTIVE;
            cnt      <= '0;
            rnd_mode <= fill_rnd;
        end else if (st == FILL_ACTIVE) begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST) st <= FILL_DONE;
        end
    end

    always_comb begin
        busy     = (st == FILL_ACTIVE);
        fill_we  = busy && !rst;
        fill_idx = cnt;
    end

    AST_BUSY_AT_RELEASE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> busy); // R1
    AST_FILL_LENGTH: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(cnt) == LAST); // R1

endmodule

// File: rtl/fim_array.sv
module fim_array
    import fim_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] widx,
    input  word_t                    wword,
    input  word_t                    wsrc,
    input  logic [$clog2(DEPTH)-1:0] ridx,
    output word_t                    rword
);

    word_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[widx] <= wword;
    end

    always_comb rword = mem[ridx];

    AST_WR_ONE_FLIP: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> $countones(mem[$past(widx)] ^ $past(wsrc)) <= 1); // R9

endmodule

// File: rtl/fault_mem.sv
module fault_mem
    import fim_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter int                SIZE_LOG2 = 6,
    parameter logic [ADDR_W-1:0] BASE      = 16'h0400,
    parameter gen_t              SEED      = 32'hACE1_0001
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fill_rnd,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata,
    output logic              rvalid,
    output logic              busy
);

    localparam int DEPTH = 1 << SIZE_LOG2;
    localparam int IDX_W = SIZE_LOG2;

    gen_t             gen;
    flip_t            rd_flip, wr_flip;
    logic             hit, rnd_mode, fill_we;
    logic [IDX_W-1:0] bus_idx, fill_idx;
    logic             acc, wr_go, rd_go;
    logic             arr_we;
    logic [IDX_W-1:0] arr_widx;
    word_t            arr_wword, arr_wsrc, rword;

    fim_lfsr #(.SEED(SEED)) u_gen (
        .clk(clk), .rst(rst), .state(gen)
    );

    fim_flip #(.TRIG_BITS(RD_TRIG_BITS)) u_rd_flip (
        .state(gen), .flip(rd_flip)
    );

    fim_flip #(.TRIG_BITS(WR_TRIG_BITS)) u_wr_flip (
        .state(gen), .flip(wr_flip)
    );

    fim_decode #(.ADDR_W(ADDR_W), .SIZE_LOG2(SIZE_LOG2), .BASE(BASE)) u_dec (
        .addr(addr), .hit(hit), .idx(bus_idx)
    );

    fim_fill #(.DEPTH(DEPTH)) u_fill (
        .clk(clk), .rst(rst), .fill_rnd(fill_rnd), .busy(busy),
        .fill_we(fill_we), .fill_idx(fill_idx), .rnd_mode(rnd_mode)
    );

    always_comb begin
        acc   = req && hit && !busy;
        wr_go = acc && we;
        rd_go = acc && !we;
        if (busy) begin
            arr_we    = fill_we;
            arr_widx  = fill_idx;
            arr_wsrc  = rnd_mode ? gen[DATA_W-1:0] : fill_pattern(3'(fill_idx));
            arr_wword = arr_wsrc;
        end else begin
            arr_we    = wr_go;
            arr_widx  = bus_idx;
            arr_wsrc  = wdata;
            arr_wword = wdata ^ wr_flip.mask;
        end
    end

    fim_array #(.DEPTH(DEPTH)) u_arr (
        .clk(clk), .rst(rst), .wr_en(arr_we), .widx(arr_widx),
        .wword(arr_wword), .wsrc(arr_wsrc), .ridx(bus_idx), .rword(rword)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= rd_go;
            if (rd_go) rdata <= rword ^ rd_flip.mask;
        end
    end

    AST_NO_READ_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |=> !rvalid); // R10
    AST_MISS_NO_RVALID: assert property (@(posedge clk) disable iff (rst)
        (req && !we && !hit) |=> !rvalid); // R7
    AST_RD_ONE_FLIP: assert property (@(posedge clk) disable iff (rst)
        rvalid |-> $countones(rdata ^ $past(rword)) <= 1); // R8

endmodule

// File: tb/fault_mem_tb.sv
`timescale 1ns/1ps
module fault_mem_tb;

    localparam int          SIZE_LOG2 = 6;
    localparam int          DEPTH     = 1 << SIZE_LOG2;
    localparam logic [15:0] BASE      = 16'h0400;
    localparam logic [31:0] TAPS      = 32'h8020_0003;
    localparam int          HIT_EDGE  = DEPTH + 40;

    function automatic logic [31:0] back_steps(input logic [31:0] t, input int n);
        logic [31:0] s;
        s = t;
        for (int i = 0; i < n; i++)
            s = s[31] ? (((s ^ TAPS) << 1) | 32'h1) : (s << 1);
        return s;
    endfunction

    localparam logic [31:0] SEED = back_steps(32'h5A5A_0003, HIT_EDGE);

    function automatic logic [31:0] fwd(input logic [31:0] s);
        return (s >> 1) ^ (s[0] ? TAPS : 32'h0);
    endfunction

    function automatic logic [15:0] rd_mask(input logic [31:0] s);
        return (s[15:0] == 16'd3) ? (16'h1 << s[23:20]) : 16'h0;
    endfunction

    function automatic logic [15:0] wr_mask(input logic [31:0] s);
        return (s[16:0] == 17'd3) ? (16'h1 << s[23:20]) : 16'h0;
    endfunction

    function automatic logic is_hit(input logic [15:0] a);
        return (a >> SIZE_LOG2) == (BASE >> SIZE_LOG2);
    endfunction

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fill_rnd = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [15:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        rvalid;
    logic        busy;

    logic [31:0] m;
    logic [15:0] mdl [DEPTH];
    logic [15:0] pat [8] = '{16'h0204, 16'h0255, 16'h4104, 16'h0020,
                             16'hF460, 16'h0080, 16'h0120, 16'h0404};
    int nvec = 0;
    int nfail = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    fault_mem #(.ADDR_W(16), .SIZE_LOG2(SIZE_LOG2), .BASE(BASE), .SEED(SEED)) u_dut (
        .clk(clk), .rst(rst), .fill_rnd(fill_rnd), .req(req), .we(we),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .busy(busy)
    );

    always_ff @(posedge clk) m <= rst ? SEED : fwd(m);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            nfail = nfail + 1;
            $display("FAIL watchdog: act=%0d cycles exp=finish", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        nvec = nvec + 1;
        if (act !== exp) begin
            nfail = nfail + 1;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic mode);
        @(negedge clk);
        rst = 1'b1; fill_rnd = mode; req = 1'b0; we = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", 16'(busy), 16'h1);
        chk("R1 rvalid in reset", 16'(rvalid), 16'h0);
        chk("R1 rdata in reset", rdata, 16'h0);
        rst = 1'b0;
    endtask

    task automatic wait_ready();
        while (busy) @(negedge clk);
    endtask

    task automatic load_pattern_model();
        for (int i = 0; i < DEPTH; i++) mdl[i] = pat[i % 8];
    endtask

    task automatic op(input logic wr, input logic [15:0] a, input logic [15:0] d,
                      output logic [31:0] snap);
        req = 1'b1; we = wr; addr = a; wdata = d;
        snap = m;
        @(negedge clk);
        req = 1'b0; we = 1'b0;
    endtask

    task automatic write_word(input logic [15:0] a, input logic [15:0] d);
        logic [31:0] s;
        @(negedge clk);
        op(1'b1, a, d, s);
        if (is_hit(a)) mdl[a[SIZE_LOG2-1:0]] = d ^ wr_mask(s);
    endtask

    task automatic read_check(input logic [15:0] a, input string tag);
        logic [31:0] s;
        @(negedge clk);
        op(1'b0, a, 16'h0, s);
        if (is_hit(a)) begin
            chk({tag, " rvalid"}, 16'(rvalid), 16'h1);
            chk(tag, rdata, mdl[a[SIZE_LOG2-1:0]] ^ rd_mask(s));
        end else begin
            chk({tag, " miss rvalid"}, 16'(rvalid), 16'h0);
        end
    endtask

    task automatic t_busy_and_ignore();
        int n;
        do_reset(1'b0);
        n = 0;
        while (busy) begin
            n = n + 1;
            chk("R10 rvalid while busy", 16'(rvalid), 16'h0);
            req = (n == 3) || (n == 5);
            we = (n == 3);
            addr = BASE + ((n == 3) ? 16'd0 : 16'd1);
            wdata = 16'hDEAD;
            @(negedge clk);
        end
        req = 1'b0; we = 1'b0;
        chk("R1 busy length", 16'(n), 16'(DEPTH));
        load_pattern_model();
        read_check(BASE, "R10 write during busy ignored");
    endtask

    task automatic t_pattern_fill();
        load_pattern_model();
        for (int i = 0; i < DEPTH; i++) read_check(BASE + 16'(i), "R2 pattern fill");
    endtask

    task automatic t_rw_patterns();
        write_word(BASE + 16'd3, 16'hFFFF);
        write_word(BASE + 16'd4, 16'h0000);
        write_word(BASE + 16'd5, 16'hA5A5);
        write_word(BASE + 16'(DEPTH - 1), 16'h5A5A);
        for (int i = 10; i < 18; i++) write_word(BASE + 16'(i), 16'(i) * 16'h0101);
        read_check(BASE + 16'd3, "R6 write all ones");
        read_check(BASE + 16'd4, "R6 write zero");
        read_check(BASE + 16'd5, "R7 read alternating");
        read_check(BASE + 16'(DEPTH - 1), "R5 top word");
        for (int i = 17; i >= 10; i--) read_check(BASE + 16'(i), "R7 reverse order reads");
    endtask

    task automatic t_window();
        write_word(BASE + 16'(DEPTH) + 16'd5, 16'h1111);
        write_word(BASE - 16'(DEPTH) + 16'd5, 16'h2222);
        write_word(16'hFFC5, 16'h3333);
        read_check(BASE + 16'd5, "R5 out-of-window writes ignored");
        read_check(BASE + 16'(DEPTH) + 16'd5, "R7 read above window");
        read_check(BASE - 16'd1, "R7 read below window");
    endtask

    task automatic t_random_fill();
        logic [31:0] s;
        do_reset(1'b1);
        s = SEED;
        for (int i = 0; i < DEPTH; i++) begin
            mdl[i] = s[15:0];
            s = fwd(s);
        end
        wait_ready();
        for (int i = 0; i < DEPTH; i++) read_check(BASE + 16'(i), "R3 R4 generator fill");
    endtask

    task automatic t_write_glitch();
        logic [31:0] s;
        do_reset(1'b0);
        load_pattern_model();
        wait_ready();
        while (m[16:0] != 17'd3) @(negedge clk);
        op(1'b1, BASE + 16'd7, 16'h0000, s);
        mdl[7] = wr_mask(s);
        chk("R9 trigger mask one-hot", 16'($countones(wr_mask(s))), 16'h1);
        read_check(BASE + 16'd7, "R9 write glitch stored");
    endtask

    task automatic t_read_glitch();
        logic [31:0] s;
        do_reset(1'b0);
        load_pattern_model();
        wait_ready();
        write_word(BASE + 16'd9, 16'h1234);
        while (m[15:0] != 16'd3) @(negedge clk);
        op(1'b0, BASE + 16'd9, 16'h0, s);
        chk("R8 glitch rvalid", 16'(rvalid), 16'h1);
        chk("R8 read glitch flips one bit", rdata, mdl[9] ^ rd_mask(s));
        chk("R8 read glitch fired", 16'($countones(rd_mask(s))), 16'h1);
        read_check(BASE + 16'd9, "R8 stored word unchanged");
    endtask

    initial begin
        t_busy_and_ignore();
        t_pattern_fill();
        t_rw_patterns();
        t_window();
        t_random_fill();
        t_write_glitch();
        t_read_glitch();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule